// File: doc/BRIEF.md
# Multiplexed Host Bus Interface

This block is the host-facing parallel port of a data acquisition controller. An external processor reaches internal registers, a conversion result FIFO and an instruction memory through it, using active-low chip select, read and write strobes, an address latch enable for buses that share address and data lines, a five-bit address and a pin that selects a 16-bit or an 8-bit data path. The bidirectional data bus is modelled as separate input, output and per-bit output-enable vectors, so the pad ring owns the actual tri-state drivers.

All host pins except the output-enable path pass through a two-stage synchronizer into the system clock domain. The block then latches the address, detects the end of each read or write strobe and steers bytes. On a write it emits one internal write beat (`wr_valid` with address, region and data). On a read it presents `acc_addr` to the register side, drives the returned `rd_data` onto the bus, and pulses `rd_done` once per word so that a FIFO can pop. In 8-bit mode a 16-bit word moves as two byte transfers, low byte first, tracked by an internal byte pointer.

The internal write stream has a valid signal and no ready: the host strobe cannot be stalled, so the sink must take each beat in the single cycle its valid is high. There is no back-pressure on any path. `rd_data` must be a combinational function of `acc_addr`.

Top module: `hbi_host_port`

## Requirements
- R1: Region decode of a five-bit address: 31 (0x1F) is the FIFO (code 2), 0 to 15 are instruction memory (code 0), 16 to 30 are control registers (code 1). `acc_region` decodes `acc_addr`; `wr_region` and `rd_done_region` decode the latched address at the end of the strobe.
- R2: `hb_oe` is non-zero only while `hb_cs_n` and `hb_rd_n` are both low, combinationally from the pins. It is 0xFFFF in 16-bit mode (`hb_narrow` low) and 0x00FF in 8-bit mode. `hb_dout` is zero whenever the port is not driving.
- R3: A write is accepted only from a strobe during which `hb_wr_n` and `hb_cs_n` were both low. `wr_valid` is high for exactly one cycle, rising at the second rising clock edge after the first edge that samples `hb_wr_n` high.
- R4: While `hb_ale` is high and `hb_cs_n` is low, the latched address follows `hb_addr`, and appears on `acc_addr` after the second rising edge following the sampling edge. While `hb_ale` is low, or while `hb_cs_n` is high, the latched address does not change. A falling `hb_ale` with `hb_cs_n` high therefore latches nothing.
- R5: In 16-bit mode `wr_data` is the `hb_din` value sampled in the last cycle in which both strobes were low, and `wr_addr` is the latched address.
- R6: In 8-bit mode `hb_oe[15:8]` stays zero. A word write takes two strobes, and only the second produces a beat, carrying {second byte, first byte} from `hb_din[7:0]`. `hb_din[15:8]` is ignored.
- R7: In 8-bit mode a read drives `rd_data[7:0]` on `hb_dout[7:0]` during the first strobe and `rd_data[15:8]` during the second. `hb_dout[15:8]` is zero.
- R8: The byte pointer returns to the low byte whenever `hb_cs_n` is sampled high. A lone low byte followed by chip select going high, then two bytes 0xA1 and 0xB2, writes 0xB2A1.
- R9: `rd_done` pulses for one cycle per completed word read: every read strobe in 16-bit mode and every second one in 8-bit mode. The timing is the same as R3, and `wr_valid` and `rd_done` are never high together.
- R10: While reset is held, `wr_valid` and `rd_done` are low, `acc_addr`, `wr_addr` and `wr_data` are zero, both region outputs are zero, and the byte pointer is at the low byte.
- R11: Read or write strobes given while `hb_cs_n` is high produce no beat and no `rd_done`, and do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_ale | input | 1 | Address latch enable, held high on non-multiplexed buses |
| hb_narrow | input | 1 | High selects the 8-bit data path, low selects 16 bits |
| hb_addr | input | 5 | Host address |
| hb_din | input | 16 | Data bus as seen from the pads |
| hb_dout | output | 16 | Data driven toward the pads |
| hb_oe | output | 16 | Per-bit output enable for the pad drivers |
| acc_addr | output | 5 | Latched address presented to the register side |
| acc_region | output | 2 | Region code of acc_addr |
| rd_data | input | 16 | Read word for acc_addr from the register side |
| rd_done | output | 1 | One-cycle pulse when a word read completes |
| rd_done_region | output | 2 | Region of the completed read |
| wr_valid | output | 1 | One-cycle internal write beat, no ready |
| wr_addr | output | 5 | Address of the write beat |
| wr_region | output | 2 | Region of the write beat |
| wr_data | output | 16 | Data of the write beat |

## Verification
A byte pointer in the wrong state shows up as swapped or repeated bytes on `hb_dout[7:0]` during the very next 8-bit read strobe, or as a wrong word or a missing `wr_valid` two edges after the second byte strobe ends. A latched address that moves while it should be frozen reaches `acc_addr`, and therefore `hb_dout` through the register side, within three clock edges. A wrong strobe-edge detector shows as a beat in the wrong cycle, a doubled pulse or a missing pulse, which a per-cycle comparison against a reference model catches on the cycle it happens.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int RGN_W  = 2;

  typedef enum logic [RGN_W-1:0] {
    RGN_IMEM = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_FIFO = 2'd2
  } region_e;

  typedef struct packed {
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic              ale;
    logic              narrow;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                  ale: 1'b0, narrow: 1'b0,
                                  addr: '0, din: '0};

  function automatic region_e decode_region(input logic [ADDR_W-1:0] a,
                                            input int unsigned imem_words,
                                            input int unsigned fifo_addr);
    if (32'(a) == fifo_addr)      return RGN_FIFO;
    else if (32'(a) < imem_words) return RGN_IMEM;
    else                          return RGN_CTRL;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch
  import hbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_ale,
  input  logic              s_cs_n,
  input  logic [ADDR_W-1:0] s_addr,
  output logic [ADDR_W-1:0] lat_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lat_addr <= '0;
    else if (s_ale && !s_cs_n)  lat_addr <= s_addr;
  end

  // R4: outside the open window the held address never moves
  assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ale || s_cs_n) |=> $stable(lat_addr));
endmodule

// File: rtl/hbi_xfer_ctl.sv
module hbi_xfer_ctl
  import hbi_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 16,
  parameter int unsigned FIFO_ADDR  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cs_n,
  input  logic              s_rd_n,
  input  logic              s_wr_n,
  input  logic              s_narrow,
  input  logic [DATA_W-1:0] s_din,
  input  logic [ADDR_W-1:0] lat_addr,
  output logic              byte_hi,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RGN_W-1:0]  wr_region,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_done,
  output logic [RGN_W-1:0]  rd_done_region
);
  logic              pv_cs_n, pv_rd_n, pv_wr_n, pv_narrow;
  logic [DATA_W-1:0] pv_din;
  logic [BYTE_W-1:0] low_q, low_nx;
  logic              hi_nx;
  logic              wr_end, rd_end, xfer_end, word_done;
  logic [DATA_W-1:0] word_data;
  region_e           lat_rgn;

  always_comb begin
    wr_end    = !pv_wr_n && !pv_cs_n && s_wr_n;
    rd_end    = !wr_end && !pv_rd_n && !pv_cs_n && s_rd_n;
    xfer_end  = wr_end || rd_end;
    word_done = xfer_end && (!pv_narrow || byte_hi);

    hi_nx = byte_hi;
    if (xfer_end && pv_narrow) hi_nx = !byte_hi;
    if (s_cs_n)                hi_nx = 1'b0;

    low_nx = low_q;
    if (wr_end && pv_narrow && !byte_hi) low_nx = pv_din[BYTE_W-1:0];

    word_data = pv_narrow ? {pv_din[BYTE_W-1:0], low_q} : pv_din;
    lat_rgn   = decode_region(lat_addr, IMEM_WORDS, FIFO_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_cs_n        <= 1'b1;
      pv_rd_n        <= 1'b1;
      pv_wr_n        <= 1'b1;
      pv_narrow      <= 1'b0;
      pv_din         <= '0;
      byte_hi        <= 1'b0;
      low_q          <= '0;
      wr_valid       <= 1'b0;
      wr_addr        <= '0;
      wr_region      <= RGN_IMEM;
      wr_data        <= '0;
      rd_done        <= 1'b0;
      rd_done_region <= RGN_IMEM;
    end else begin
      pv_cs_n   <= s_cs_n;
      pv_rd_n   <= s_rd_n;
      pv_wr_n   <= s_wr_n;
      pv_narrow <= s_narrow;
      pv_din    <= s_din;
      byte_hi   <= hi_nx;
      low_q     <= low_nx;
      wr_valid  <= wr_end && word_done;
      rd_done   <= rd_end && word_done;
      if (wr_end && word_done) begin
        wr_data   <= word_data;
        wr_addr   <= lat_addr;
        wr_region <= lat_rgn;
      end
      if (rd_end && word_done) rd_done_region <= lat_rgn;
    end
  end

  // R3: a write beat lasts a single cycle
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R9: read completion lasts a single cycle and never meets a write beat
  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_done));
  // R8: a sampled chip-select release parks the pointer on the low byte
  assert_ptr_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> !byte_hi);
  // R11: nothing completes out of a cycle in which chip select was high
  assert_cs_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pv_cs_n |=> !(wr_valid || rd_done));
endmodule

// File: rtl/hbi_read_steer.sv
module hbi_read_steer
  import hbi_pkg::*;
(
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              narrow,
  input  logic              byte_hi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] oe
);
  logic              drive;
  logic [BYTE_W-1:0] sel_byte;

  assign drive    = !cs_n && !rd_n;
  assign sel_byte = rd_data[(byte_hi ? BYTE_W : 0) +: BYTE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign oe[BYTE_W-1:0]   = drive ? '1 : '0;
      assign dout[BYTE_W-1:0] = !drive ? '0 :
                                (narrow ? sel_byte : rd_data[BYTE_W-1:0]);
    end else begin : g_up
      assign oe[g*BYTE_W +: BYTE_W]   = (drive && !narrow) ? '1 : '0;
      assign dout[g*BYTE_W +: BYTE_W] = (drive && !narrow) ?
                                        rd_data[g*BYTE_W +: BYTE_W] : '0;
    end
  end
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int unsigned IMEM_WORDS = 16,
  parameter int unsigned FIFO_ADDR  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_cs_n,
  input  logic              hb_rd_n,
  input  logic              hb_wr_n,
  input  logic              hb_ale,
  input  logic              hb_narrow,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_din,
  output logic [DATA_W-1:0] hb_dout,
  output logic [DATA_W-1:0] hb_oe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [RGN_W-1:0]  acc_region,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic [RGN_W-1:0]  rd_done_region,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RGN_W-1:0]  wr_region,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PW = $bits(pins_t);

  pins_t          raw, cur;
  logic [PW-1:0]  cur_v;
  logic           byte_hi;

  assign raw = '{cs_n: hb_cs_n, rd_n: hb_rd_n, wr_n: hb_wr_n, ale: hb_ale,
                 narrow: hb_narrow, addr: hb_addr, din: hb_din};

  hbi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (cur_v)
  );
  assign cur = pins_t'(cur_v);

  hbi_addr_latch u_alat (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ale    (cur.ale),
    .s_cs_n   (cur.cs_n),
    .s_addr   (cur.addr),
    .lat_addr (acc_addr)
  );

  assign acc_region = decode_region(acc_addr, IMEM_WORDS, FIFO_ADDR);

  hbi_xfer_ctl #(.IMEM_WORDS(IMEM_WORDS), .FIFO_ADDR(FIFO_ADDR)) u_xfer (
    .clk            (clk),
    .rst_n          (rst_n),
    .s_cs_n         (cur.cs_n),
    .s_rd_n         (cur.rd_n),
    .s_wr_n         (cur.wr_n),
    .s_narrow       (cur.narrow),
    .s_din          (cur.din),
    .lat_addr       (acc_addr),
    .byte_hi        (byte_hi),
    .wr_valid       (wr_valid),
    .wr_addr        (wr_addr),
    .wr_region      (wr_region),
    .wr_data        (wr_data),
    .rd_done        (rd_done),
    .rd_done_region (rd_done_region)
  );

  hbi_read_steer u_steer (
    .cs_n    (hb_cs_n),
    .rd_n    (hb_rd_n),
    .narrow  (hb_narrow),
    .byte_hi (byte_hi),
    .rd_data (rd_data),
    .dout    (hb_dout),
    .oe      (hb_oe)
  );

  // R2: pads are never driven outside a selected read
  assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_cs_n || hb_rd_n) |-> (hb_oe == '0 && hb_dout == '0));
  // R6: the upper lane stays released in 8-bit mode
  assert_upper_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hb_narrow |-> (hb_oe[DATA_W-1:BYTE_W] == '0));
  // R1: a write beat into the FIFO slot carries the FIFO region code
  assert_fifo_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && 32'(wr_addr) == FIFO_ADDR) |-> (wr_region == RGN_FIFO));
endmodule

// File: tb/hbi_host_port_tb.sv
module hbi_host_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0, narrow = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] hb_dout, hb_oe, rd_data, wr_data;
  logic [4:0]  acc_addr, wr_addr;
  logic [1:0]  acc_region, rd_done_region, wr_region;
  logic        rd_done, wr_valid;

  function automatic logic [15:0] reg_image(input logic [4:0] a);
    return {3'b101, a, ~a, 3'b010};
  endfunction
  assign rd_data = reg_image(acc_addr);

  hbi_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_rd_n(rd_n), .hb_wr_n(wr_n),
    .hb_ale(ale), .hb_narrow(narrow), .hb_addr(addr), .hb_din(din),
    .hb_dout(hb_dout), .hb_oe(hb_oe), .acc_addr(acc_addr), .acc_region(acc_region),
    .rd_data(rd_data), .rd_done(rd_done), .rd_done_region(rd_done_region),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_region(wr_region), .wr_data(wr_data)
  );

  typedef struct packed {
    logic cs; logic rd; logic wr; logic al; logic nar;
    logic [4:0] a; logic [15:0] d;
  } smp_t;
  localparam smp_t IDLE = '{cs: 1'b1, rd: 1'b1, wr: 1'b1, al: 1'b0, nar: 1'b0, a: '0, d: '0};

  int compared = 0, mismatched = 0, cyc = 0, dut_wr_cnt = 0;
  bit done = 0;
  logic [15:0] last_wr = '0;

  smp_t hist[$];
  smp_t mc, mp;
  logic [4:0]  m_lat = '0, e_wr_addr = '0;
  logic        m_ptr = 1'b0, e_wr_valid = 1'b0, e_rd_done = 1'b0, wend, rend;
  logic [7:0]  m_low = '0;
  logic [15:0] e_wr_data = '0;
  logic [1:0]  e_wr_rgn = '0, e_rd_rgn = '0;

  function automatic logic [1:0] rgn(input logic [4:0] a);
    if (a == 5'd31) return 2'd2;
    if (a < 5'd16)  return 2'd0;
    return 2'd1;
  endfunction

  initial repeat (4) hist.push_back(IDLE);

  // reference model: pins are seen two edges late, strobe ends one edge after that
  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      repeat (4) hist.push_back(IDLE);
      m_lat = '0; m_ptr = 0; m_low = '0; e_wr_valid = 0; e_rd_done = 0;
      e_wr_addr = '0; e_wr_data = '0; e_wr_rgn = '0; e_rd_rgn = '0;
    end else begin
      hist.push_front('{cs: cs_n, rd: rd_n, wr: wr_n, al: ale, nar: narrow, a: addr, d: din});
      while (hist.size() > 6) void'(hist.pop_back());
      mc = hist[2];
      mp = hist[3];
      e_wr_valid = 0;
      e_rd_done  = 0;
      wend = !mp.wr && !mp.cs && mc.wr;
      rend = !wend && !mp.rd && !mp.cs && mc.rd;
      if (wend) begin
        if (!mp.nar) begin
          e_wr_valid = 1; e_wr_data = mp.d; e_wr_addr = m_lat; e_wr_rgn = rgn(m_lat);
        end else if (!m_ptr) begin
          m_low = mp.d[7:0]; m_ptr = 1;
        end else begin
          e_wr_valid = 1; e_wr_data = {mp.d[7:0], m_low}; e_wr_addr = m_lat;
          e_wr_rgn = rgn(m_lat); m_ptr = 0;
        end
      end
      if (rend) begin
        if (!mp.nar || m_ptr) begin
          e_rd_done = 1; e_rd_rgn = rgn(m_lat);
        end
        if (mp.nar) m_ptr = !m_ptr;
      end
      if (mc.cs) m_ptr = 0;
      if (mc.al && !mc.cs) m_lat = mc.a;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] rdv, e_oe, e_dout;
    bit drv;
    string tr;
    tr = rst_n ? "" : "R10 ";
    rdv = reg_image(m_lat);
    drv = !cs_n && !rd_n;
    e_oe = !drv ? 16'h0 : (narrow ? 16'h00FF : 16'hFFFF);
    e_dout = !drv ? 16'h0 : (narrow ? {8'h00, (m_ptr ? rdv[15:8] : rdv[7:0])} : rdv);
    chk("R2 hb_oe", hb_oe, e_oe);
    chk("R7 hb_dout", hb_dout, e_dout);
    chk({tr, "R4 acc_addr"}, 16'(acc_addr), 16'(m_lat));
    chk({tr, "R1 acc_region"}, 16'(acc_region), 16'(rgn(m_lat)));
    chk({tr, "R3 wr_valid"}, 16'(wr_valid), 16'(e_wr_valid));
    chk({tr, "R5 wr_data"}, wr_data, e_wr_data);
    chk({tr, "R5 wr_addr"}, 16'(wr_addr), 16'(e_wr_addr));
    chk({tr, "R1 wr_region"}, 16'(wr_region), 16'(e_wr_rgn));
    chk({tr, "R9 rd_done"}, 16'(rd_done), 16'(e_rd_done));
    chk({tr, "R9 rd_done_region"}, 16'(rd_done_region), 16'(e_rd_rgn));
    if (wr_valid === 1'b1) begin
      dut_wr_cnt++;
      last_wr = wr_data;
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (!done) compare_all();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic open_plain(input logic [4:0] a);
    @(negedge clk); ale = 1; addr = a; cs_n = 0;
    wait_cyc(2);
  endtask
  task automatic open_mux(input logic [4:0] a);
    @(negedge clk); ale = 1; addr = a; cs_n = 0;
    wait_cyc(2);
    ale = 0; addr = ~a;
    wait_cyc(2);
  endtask
  task automatic close_acc();
    cs_n = 1;
    wait_cyc(4);
  endtask
  task automatic wstrobe(input logic [15:0] d);
    din = d; wr_n = 0;
    wait_cyc(3);
    wr_n = 1;
    wait_cyc(3);
  endtask
  task automatic rstrobe();
    rd_n = 0;
    wait_cyc(3);
    rd_n = 1;
    wait_cyc(3);
  endtask

  initial begin
    int base;
    logic [15:0] d;
    logic [4:0]  a;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(3);

    narrow = 0;                                    // R5: 16-bit plain write
    open_plain(5'h03); wstrobe(16'h1234); close_acc();
    chk("R5 word", last_wr, 16'h1234);
    open_plain(5'h12); rstrobe(); close_acc();     // R9: 16-bit read
    open_mux(5'h1F); wstrobe(16'hABCD); close_acc();  // R4: address survives data phase
    chk("R4 mux write", last_wr, 16'hABCD);
    open_mux(5'h1F); rstrobe(); close_acc();

    @(negedge clk); ale = 1; addr = 5'h0A; cs_n = 1;   // R4: ALE falls with CS high
    wait_cyc(3); ale = 0; addr = 5'h15;
    wait_cyc(3); cs_n = 0;
    wait_cyc(2); rstrobe(); close_acc();
    chk("R4 no latch", 16'(acc_addr), 16'h001F);

    narrow = 1;                                    // R6: byte-wide write
    open_plain(5'h14); wstrobe(16'hFF5A); wstrobe(16'hEEC3); close_acc();
    chk("R6 bytes", last_wr, 16'hC35A);
    open_mux(5'h07); rstrobe(); rstrobe(); close_acc();  // R7

    open_plain(5'h1C); wstrobe(16'h0011);          // R8: pointer parks on CS release
    cs_n = 1; wait_cyc(3); cs_n = 0; wait_cyc(2);
    wstrobe(16'h00A1); wstrobe(16'h00B2); close_acc();
    chk("R8 restart", last_wr, 16'hB2A1);

    base = dut_wr_cnt;                             // R11: deselected strobes
    @(negedge clk); ale = 1; addr = 5'h02; cs_n = 1;
    wstrobe(16'h7777); rstrobe(); wstrobe(16'h6666);
    chk("R11 no beat", 16'(dut_wr_cnt), 16'(base));
    open_plain(5'h02); wstrobe(16'h0044); wstrobe(16'h0055); close_acc();
    chk("R11 ptr kept", last_wr, 16'h5544);

    for (int i = 0; i < 12; i++) begin             // R3: mixed sweep
      a = 5'(i * 7 + 3);
      d = 16'(i * 16'h1357) ^ 16'h2468;
      @(negedge clk); narrow = i[1];
      if (i % 3 == 0) open_mux(a); else open_plain(a);
      if (narrow) begin
        wstrobe({8'h00, d[7:0]}); wstrobe({8'h00, d[15:8]});
        rstrobe(); rstrobe();
      end else begin
        wstrobe(d); rstrobe();
      end
      close_acc();
      chk("R3 sweep", last_wr, d);
    end

    wait_cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule